// File: doc/BRIEF.md
# Write-Through Snooping Data Cache

This block is a small direct-mapped data cache for one processor on a shared bus. It writes through and does not allocate on writes. A read that misses fetches the word over the bus and installs it. A read that hits is answered locally. Every write, hit or miss, is sent to the bus, and a write that hits also refreshes the local copy. Each line is either valid or invalid. The cache stays coherent by watching the bus for writes made by other agents: when such a write targets a word held valid, that line is invalidated and not updated.

The processor side uses a valid/ready request handshake and receives a one-cycle response pulse carrying the read data and a hit flag. The bus side raises a request that is held until a grant, then waits for a completion strobe. A separate snoop input reports transactions made by other agents. The bus is expected to filter out this cache's own transactions from that input.

Top module: `wt_snoop_cache`

## Requirements
- R1: While reset is high and in the first cycle after it, the cache holds every line invalid, keeps `cpu_req_ready` high, and keeps `cpu_resp_valid` and `bus_req_valid` low. After reset, the first read to any index misses.
- R2: A read that misses raises exactly one bus read (`bus_req_write`=0) to the requested word address. Its response has `cpu_resp_hit`=0 and carries `bus_rdata` from the completion cycle. The line then becomes valid, so a repeated read hits.
- R3: A read that hits raises no bus transaction. Its response appears in the cycle after acceptance with `cpu_resp_hit`=1 and the stored word.
- R4: Every accepted write raises exactly one bus write (`bus_req_write`=1) carrying the request address and data, starting in the cycle after acceptance. Its response follows bus completion, and `cpu_resp_hit` reports whether the line was valid.
- R5: A write that misses installs nothing, so a later read of that address misses.
- R6: A write that hits replaces the stored word and keeps the line valid, so a later read hits and returns the new data.
- R7: Addresses split into index (the low log2(LINES) bits) and tag (the remaining upper bits). A snooped write (`snoop_valid`=1, `snoop_write`=1) whose address matches a valid line invalidates that line.
- R8: A snooped read (`snoop_write`=0) changes nothing. A snooped write to the same index with a different tag also changes nothing.
- R9: When a snooped write invalidates a line in the same cycle a processor request to that address is accepted, the request sees the line as invalid. A read misses, and a write reports a miss and leaves the line invalid.
- R10: If a snooped write to the address of an outstanding read miss arrives in the cycle of `bus_done`, the returned data is still delivered, but the line is not installed.
- R11: `cpu_req_ready` is low from the cycle after accepting a request that needs the bus until the cycle after `bus_done`. `bus_req_valid`, address, write flag and data stay stable until `bus_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Write data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_hit | output | 1 | Line was valid when the request was accepted |
| cpu_resp_rdata | output | DW | Read data (zero for writes) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_addr | output | AW | Bus word address |
| bus_req_wdata | output | DW | Bus write data |
| bus_gnt | input | 1 | Bus grants the pending request |
| bus_done | input | 1 | Granted transaction completes |
| bus_rdata | input | DW | Read data, valid with `bus_done` |
| snoop_valid | input | 1 | Another agent's transaction is on the bus |
| snoop_write | input | 1 | That transaction is a write |
| snoop_addr | input | AW | That transaction's word address |

## Verification
The hardest situations to reach are the collisions between the snoop input and the cache's own activity. One is a foreign write that lands in exactly the cycle a processor request is accepted. The other is a foreign write that lands in the cycle the bus completes a read miss. The bench reaches the first by driving the snoop input in the same cycle as the processor request, both as directed cases and at random over a small address pool. It reaches the second by arming its bus responder to put a snooped write to the outstanding address alongside `bus_done`. A follow-up read then shows whether the line was kept.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int WTC_AW    = 10;
    localparam int WTC_DW    = 32;
    localparam int WTC_LINES = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BREQ = 2'd1,
        ST_WAIT = 2'd2
    } wtc_state_e;

endpackage

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
    parameter int TAGW = 6
) (
    input  logic            line_valid,
    input  logic [TAGW-1:0] line_tag,
    input  logic [TAGW-1:0] probe_tag,
    output logic            match
);
    always_comb match = line_valid && (line_tag == probe_tag);
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES = 16,
    parameter int TAGW  = 6,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] pa_idx,
    output logic            pa_valid,
    output logic [TAGW-1:0] pa_tag,
    output logic [DW-1:0]   pa_data,
    input  logic [IDXW-1:0] pb_idx,
    output logic            pb_valid,
    output logic [TAGW-1:0] pb_tag,
    input  logic            inv_en,
    input  logic [IDXW-1:0] inv_idx,
    input  logic            fill_en,
    input  logic [IDXW-1:0] fill_idx,
    input  logic [TAGW-1:0] fill_tag,
    input  logic [DW-1:0]   fill_data,
    input  logic            upd_en,
    input  logic [IDXW-1:0] upd_idx,
    input  logic [DW-1:0]   upd_data
);
    logic [LINES-1:0] valid_vec;
    logic [TAGW-1:0]  tag_mem  [LINES];
    logic [DW-1:0]    data_mem [LINES];

    // Per-line state bit: a fill installs a new tag and wins over an invalidation
    // of the previous occupant of the same index.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic v_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (fill_en && fill_idx == IDXW'(i)) begin
                v_q <= 1'b1;
            end else if (inv_en && inv_idx == IDXW'(i)) begin
                v_q <= 1'b0;
            end
        end
        assign valid_vec[i] = v_q;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx]  <= fill_tag;
            data_mem[fill_idx] <= fill_data;
        end else if (upd_en) begin
            data_mem[upd_idx] <= upd_data;
        end
    end

    always_comb begin
        pa_valid = valid_vec[pa_idx];
        pa_tag   = tag_mem[pa_idx];
        pa_data  = data_mem[pa_idx];
        pb_valid = valid_vec[pb_idx];
        pb_tag   = tag_mem[pb_idx];
    end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
    import wtc_pkg::*;
#(
    parameter int AW    = WTC_AW,
    parameter int DW    = WTC_DW,
    parameter int LINES = WTC_LINES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_resp_valid,
    output logic          cpu_resp_hit,
    output logic [DW-1:0] cpu_resp_rdata,
    output logic          bus_req_valid,
    output logic          bus_req_write,
    output logic [AW-1:0] bus_req_addr,
    output logic [DW-1:0] bus_req_wdata,
    input  logic          bus_gnt,
    input  logic          bus_done,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snoop_valid,
    input  logic          snoop_write,
    input  logic [AW-1:0] snoop_addr
);
    localparam int IDXW = $clog2(LINES);
    localparam int TAGW = AW - IDXW;

    typedef struct packed {
        logic          wr;
        logic          hit;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } pend_t;

    wtc_state_e state_q;
    pend_t      pend_q;
    logic          resp_v_q, resp_hit_q;
    logic [DW-1:0] resp_data_q;

    logic [IDXW-1:0] cpu_idx, snp_idx, pend_idx;
    logic [TAGW-1:0] cpu_tag, snp_tag, pend_tag;
    logic            a_valid, b_valid;
    logic [TAGW-1:0] a_tag, b_tag;
    logic [DW-1:0]   a_data;
    logic            cpu_match, snp_match, snp_kill, cpu_hit, accept;
    logic            fill_en, upd_en, fill_clash;

    always_comb begin
        cpu_idx  = cpu_req_addr[IDXW-1:0];
        cpu_tag  = cpu_req_addr[AW-1:IDXW];
        snp_idx  = snoop_addr[IDXW-1:0];
        snp_tag  = snoop_addr[AW-1:IDXW];
        pend_idx = pend_q.addr[IDXW-1:0];
        pend_tag = pend_q.addr[AW-1:IDXW];
    end

    wtc_line_store #(.LINES(LINES), .TAGW(TAGW), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .pa_idx   (cpu_idx),
        .pa_valid (a_valid),
        .pa_tag   (a_tag),
        .pa_data  (a_data),
        .pb_idx   (snp_idx),
        .pb_valid (b_valid),
        .pb_tag   (b_tag),
        .inv_en   (snp_kill),
        .inv_idx  (snp_idx),
        .fill_en  (fill_en),
        .fill_idx (pend_idx),
        .fill_tag (pend_tag),
        .fill_data(bus_rdata),
        .upd_en   (upd_en),
        .upd_idx  (cpu_idx),
        .upd_data (cpu_req_wdata)
    );

    wtc_tag_match #(.TAGW(TAGW)) u_cpu_cmp (
        .line_valid(a_valid), .line_tag(a_tag), .probe_tag(cpu_tag), .match(cpu_match)
    );

    wtc_tag_match #(.TAGW(TAGW)) u_snp_cmp (
        .line_valid(b_valid), .line_tag(b_tag), .probe_tag(snp_tag), .match(snp_match)
    );

    always_comb begin
        snp_kill   = snoop_valid && snoop_write && snp_match;
        // Snoop goes first: an invalidation of this very line turns the lookup into a miss.
        cpu_hit    = cpu_match && !(snp_kill && (snp_idx == cpu_idx));
        accept     = cpu_req_valid && (state_q == ST_IDLE);
        upd_en     = accept && cpu_req_write && cpu_hit;
        fill_clash = snoop_valid && snoop_write && (snoop_addr == pend_q.addr);
        fill_en    = (state_q == ST_WAIT) && bus_done && !pend_q.wr && !fill_clash;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pend_q      <= '0;
            resp_v_q    <= 1'b0;
            resp_hit_q  <= 1'b0;
            resp_data_q <= '0;
        end else begin
            resp_v_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!cpu_req_write && cpu_hit) begin
                            resp_v_q    <= 1'b1;
                            resp_hit_q  <= 1'b1;
                            resp_data_q <= a_data;
                        end else begin
                            pend_q  <= '{wr: cpu_req_write, hit: cpu_hit,
                                         addr: cpu_req_addr, data: cpu_req_wdata};
                            state_q <= ST_BREQ;
                        end
                    end
                end
                ST_BREQ: begin
                    if (bus_gnt) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (bus_done) begin
                        resp_v_q    <= 1'b1;
                        resp_hit_q  <= pend_q.hit;
                        resp_data_q <= pend_q.wr ? '0 : bus_rdata;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_req_ready  = (state_q == ST_IDLE);
        cpu_resp_valid = resp_v_q;
        cpu_resp_hit   = resp_hit_q;
        cpu_resp_rdata = resp_data_q;
        bus_req_valid  = (state_q == ST_BREQ);
        bus_req_write  = pend_q.wr;
        bus_req_addr   = pend_q.addr;
        bus_req_wdata  = pend_q.data;
    end
endmodule

// File: rtl/wtc_checks.sv
module wtc_checks #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_req_valid,
    input logic          cpu_req_ready,
    input logic          cpu_req_write,
    input logic [AW-1:0] cpu_req_addr,
    input logic [DW-1:0] cpu_req_wdata,
    input logic          cpu_resp_valid,
    input logic          bus_req_valid,
    input logic          bus_req_write,
    input logic [AW-1:0] bus_req_addr,
    input logic [DW-1:0] bus_req_wdata,
    input logic          bus_gnt
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (cpu_req_ready && !cpu_resp_valid && !bus_req_valid));

    a_r2_miss_reads_bus: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready && !cpu_req_write) |=>
        (!bus_req_valid || (!bus_req_write && bus_req_addr == $past(cpu_req_addr))));

    a_r3_bus_only_after_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_valid) |-> $past(cpu_req_valid && cpu_req_ready));

    a_r4_write_goes_out: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready && cpu_req_write) |=>
        (bus_req_valid && bus_req_write && bus_req_addr == $past(cpu_req_addr)
         && bus_req_wdata == $past(cpu_req_wdata)));

    a_r11_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_gnt) |=>
        (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write)
         && $stable(bus_req_wdata)));

    a_r11_stall_while_busy: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !cpu_req_ready);
endmodule

bind wt_snoop_cache wtc_checks #(.AW(AW), .DW(DW)) u_checks (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid),
    .bus_req_valid (bus_req_valid),
    .bus_req_write (bus_req_write),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_gnt       (bus_gnt)
);

// File: tb/sim_wt_snoop_cache.sv
`timescale 1ns/1ps
module sim_wt_snoop_cache;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LINES = 16;
    localparam int IDXW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req_valid, bus_req_write;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_wdata;
    logic          bus_gnt = 1'b0, bus_done = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          tb_snp_v = 1'b0, tb_snp_w = 1'b0;
    logic [AW-1:0] tb_snp_a = '0;
    logic          rs_snp_v = 1'b0;
    logic [AW-1:0] rs_snp_a = '0;
    logic          snoop_valid, snoop_write;
    logic [AW-1:0] snoop_addr;

    assign snoop_valid = tb_snp_v | rs_snp_v;
    assign snoop_write = rs_snp_v ? 1'b1 : tb_snp_w;
    assign snoop_addr  = rs_snp_v ? rs_snp_a : tb_snp_a;

    wt_snoop_cache #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_hit(cpu_resp_hit), .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snoop_valid(snoop_valid), .snoop_write(snoop_write), .snoop_addr(snoop_addr)
    );

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [DW-1:0] mem [1 << AW];
    logic          m_valid [LINES];
    logic [AW-IDXW-1:0] m_tag [LINES];

    // Responder bookkeeping
    int            txn_count = 0;
    logic          last_w;
    logic [AW-1:0] last_a;
    logic [DW-1:0] last_d;
    logic          busy = 1'b0;
    int            lat = 0;
    logic          collide_arm = 1'b0;
    logic [DW-1:0] collide_val = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Simple bus memory: random grant and completion delays.
    always @(negedge clk) begin
        rs_snp_v = 1'b0;
        if (rst) begin
            bus_gnt = 1'b0; bus_done = 1'b0; busy = 1'b0;
        end else if (bus_done) begin
            bus_done = 1'b0;
        end else if (busy) begin
            if (lat == 0) begin
                bus_done = 1'b1;
                busy = 1'b0;
                if (!last_w) begin
                    bus_rdata = mem[last_a];
                    if (collide_arm) begin
                        rs_snp_v = 1'b1;
                        rs_snp_a = last_a;
                        mem[last_a] = collide_val;
                        collide_arm = 1'b0;
                    end
                end else begin
                    mem[last_a] = last_d;
                end
            end else begin
                lat--;
            end
        end else if (bus_gnt) begin
            bus_gnt = 1'b0;
            busy = 1'b1;
            lat = $urandom % 4;
        end else if (bus_req_valid && ($urandom % 3 != 0)) begin
            bus_gnt = 1'b1;
            last_w = bus_req_write;
            last_a = bus_req_addr;
            last_d = bus_req_wdata;
            txn_count++;
        end
    end

    function automatic bit model_hit(input logic [AW-1:0] a);
        return m_valid[a[IDXW-1:0]] && (m_tag[a[IDXW-1:0]] == a[AW-1:IDXW]);
    endfunction

    // Foreign write seen by the model: drop the line, change memory.
    function automatic void model_snoop_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        if (model_hit(a)) m_valid[a[IDXW-1:0]] = 1'b0;
        mem[a] = v;
    endfunction

    task automatic snoop_only(input bit wr, input logic [AW-1:0] a);
        tb_snp_v = 1'b1; tb_snp_w = wr; tb_snp_a = a;
        if (wr) model_snoop_write(a, $urandom);
        @(negedge clk);
        tb_snp_v = 1'b0; tb_snp_w = 1'b0;
    endtask

    // One processor access; optional foreign write in the acceptance cycle.
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit snp, input logic [AW-1:0] sa, input string rq);
        bit exp_hit, armed, stalled_ok;
        int base;
        logic [DW-1:0] exp_d;
        while (!cpu_req_ready) @(negedge clk);
        if (snp) begin
            tb_snp_v = 1'b1; tb_snp_w = 1'b1; tb_snp_a = sa;
            model_snoop_write(sa, $urandom);
        end
        exp_hit = model_hit(a);
        exp_d   = mem[a];
        armed   = collide_arm;
        base    = txn_count;
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0; tb_snp_v = 1'b0; tb_snp_w = 1'b0;
        stalled_ok = 1'b1;
        while (!cpu_resp_valid) begin
            if (cpu_req_ready) stalled_ok = 1'b0;
            @(negedge clk);
        end
        chk(cpu_resp_hit == exp_hit, rq, "hit flag", 32'(cpu_resp_hit), 32'(exp_hit));
        if (!wr) chk(cpu_resp_rdata == exp_d, rq, "read data", cpu_resp_rdata, exp_d);
        if (wr || !exp_hit) begin
            chk(txn_count == base + 1, "R4/R2", "bus transaction count", 32'(txn_count - base), 32'd1);
            chk(last_w == wr && last_a == a, rq, "bus kind/address",
                {21'd0, last_w, last_a}, {21'd0, wr, a});
            if (wr) chk(last_d == d, "R4", "bus write data", last_d, d);
            chk(stalled_ok && cpu_req_ready, "R11", "ready low while on bus", 32'(stalled_ok), 32'd1);
        end else begin
            chk(txn_count == base, "R3", "no bus transaction on read hit", 32'(txn_count - base), 32'd0);
        end
        if (!wr && !exp_hit && !armed) begin
            m_valid[a[IDXW-1:0]] = 1'b1;
            m_tag[a[IDXW-1:0]]   = a[AW-1:IDXW];
        end
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=done", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20250));
        for (int i = 0; i < (1 << AW); i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end

        repeat (4) @(negedge clk);
        chk(cpu_req_ready && !cpu_resp_valid && !bus_req_valid, "R1", "idle outputs in reset",
            {29'd0, cpu_req_ready, cpu_resp_valid, bus_req_valid}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_req_ready && !cpu_resp_valid && !bus_req_valid, "R1", "idle outputs after reset",
            {29'd0, cpu_req_ready, cpu_resp_valid, bus_req_valid}, 32'h4);

        // R1, R2: every index misses after reset, then fills
        for (int i = 0; i < LINES; i++) access(1'b0, AW'(i), '0, 1'b0, '0, "R1");
        access(1'b0, 10'h005, '0, 1'b0, '0, "R2");   // now a hit (R3)
        access(1'b0, 10'h009, '0, 1'b0, '0, "R3");
        // R4, R6: write hit updates copy
        access(1'b1, 10'h005, 32'hCAFE0005, 1'b0, '0, "R6");
        access(1'b0, 10'h005, '0, 1'b0, '0, "R6");
        // R5: write miss does not allocate
        access(1'b1, 10'h3F0, 32'h0BAD03F0, 1'b0, '0, "R5");
        access(1'b0, 10'h3F0, '0, 1'b0, '0, "R5");
        // R7: snooped write invalidates
        snoop_only(1'b1, 10'h005);
        access(1'b0, 10'h005, '0, 1'b0, '0, "R7");
        // R8: snooped read and same-index other-tag write leave the line
        snoop_only(1'b0, 10'h003);
        access(1'b0, 10'h003, '0, 1'b0, '0, "R8");
        snoop_only(1'b1, 10'h013);
        access(1'b0, 10'h003, '0, 1'b0, '0, "R8");
        // R9: snoop in the acceptance cycle wins
        access(1'b0, 10'h004, '0, 1'b1, 10'h004, "R9");
        access(1'b1, 10'h006, 32'h66666666, 1'b1, 10'h006, "R9");
        access(1'b0, 10'h006, '0, 1'b0, '0, "R9");
        // R10: snoop at fill completion suppresses install
        snoop_only(1'b1, 10'h007);
        collide_val = 32'h77777777;
        collide_arm = 1'b1;
        access(1'b0, 10'h007, '0, 1'b0, '0, "R10");
        access(1'b0, 10'h007, '0, 1'b0, '0, "R10");

        // Random mix over a small pool of tags
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [AW-1:0] a, sa;
            op = $urandom % 100;
            a  = {AW-IDXW'($urandom % 3), IDXW'($urandom)};
            sa = ($urandom % 2) ? a : {AW-IDXW'($urandom % 3), IDXW'($urandom)};
            if (op < 40)      access(1'b0, a, '0, ($urandom % 8 == 0), sa, "R2/R3");
            else if (op < 65) access(1'b1, a, $urandom, ($urandom % 8 == 0), sa, "R4");
            else if (op < 85) snoop_only(1'b1, a);
            else              snoop_only(1'b0, a);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule